// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital side of three analog voltage comparators. Each comparator delivers one raw, asynchronous output bit. The block brings each bit into the clock domain through a two-flop synchronizer and holds the channel invalid for a programmable settle time after the channel is switched on. Once the channel is valid, the block watches the synchronized level for transitions. A low-to-high transition sets that channel's sticky rising flag. A high-to-low transition sets its sticky falling flag.

Each channel has its own on/off bit and two independent interrupt enables, one for rising events and one for falling events. A channel can therefore interrupt on rising events, on falling events or on both. One global enable gates the combined request. A flag stays set until it is cleared with a one-cycle write-one-to-clear pulse. The live, blanked comparator level is always visible on a status output.

Top module: `cmp_edge_irq_top`

## Requirements
- R1: The status bit of an enabled, settled channel follows its raw input with two cycles of latency. A raw change driven before clock edge k appears on status after edge k+1 and not earlier.
- R2: On a valid channel, a raw change from 0 to 1 sets rise_flag and a change from 1 to 0 sets fall_flag. The flag is first seen after the third clock edge that follows the raw change.
- R3: A set flag stays set through any later edges of either polarity, until a clear pulse for that flag arrives.
- R4: A 1 on clr_rise[i] or clr_fall[i] for one cycle, with no new event of that polarity in that cycle, makes the flag 0 after that clock edge. Other flags are not affected.
- R5: If an event of a polarity and a clear of the same flag fall in the same cycle, the flag stays 1.
- R6: While ch_en[i] is 0, status[i] reads 0 and no edge sets a flag of channel i. Flags already set when the channel is switched off keep their value.
- R7: After ch_en[i] rises, status[i] reads 0 and edges are ignored for settle_cycles clock edges. Status becomes valid after exactly settle_cycles edges. A settle_cycles value of 0 makes the channel valid in the same cycle ch_en[i] is 1.
- R8: irq = glob_ie AND OR over i of ((rise_flag[i] AND rise_ie[i]) OR (fall_flag[i] AND fall_ie[i])). irq is combinational from the flags and the enables. Flags are set whatever the interrupt enables are.
- R9: Bit i of every per-channel vector belongs to channel i. Events on one channel never change another channel's flags.
- R10: A synchronous active-high reset clears all flags, the synchronizers and the settle counters. After reset, status, flags and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | NCH | Raw comparator outputs, asynchronous |
| ch_en | input | NCH | Channel on/off |
| rise_ie | input | NCH | Rising-event interrupt enables |
| fall_ie | input | NCH | Falling-event interrupt enables |
| glob_ie | input | 1 | Global interrupt enable |
| settle_cycles | input | SETTLE_W | Blanking time after enable, in clock cycles |
| clr_rise | input | NCH | Write-one-to-clear pulses for rising flags |
| clr_fall | input | NCH | Write-one-to-clear pulses for falling flags |
| status | output | NCH | Synchronized comparator level, 0 while blanked |
| rise_flag | output | NCH | Sticky rising-event flags |
| fall_flag | output | NCH | Sticky falling-event flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge that lands in the same cycle as a clear of the same flag. The edge only becomes visible internally two synchronizer stages after the raw change. The stimulus drives the raw input and then waits exactly two clock edges. It then asserts the clear for one cycle, so that the clear and the internal edge coincide on the third edge. Transitions hidden inside a long settle window are produced the same way: the input is toggled twice while the counter is still running, and the bench confirms that no flag appears once the channel becomes valid.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

    localparam int NCH_DEF      = 3;
    localparam int SETTLE_W_DEF = 8;
    localparam int SYNC_STAGES  = 2;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } edge_ev_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } flag_pair_t;

    function automatic edge_ev_t classify_edge(input logic valid, input logic cur, input logic prev);
        if (!valid || (cur == prev)) return EV_NONE;
        return cur ? EV_RISE : EV_FALL;
    endfunction

    function automatic logic next_flag(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync
    import cmp_irq_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cmp_settle.sv
module cmp_settle
    import cmp_irq_pkg::*;
#(
    parameter int W = SETTLE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         valid
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)   cnt <= '0;
        else if (cnt < limit) cnt <= cnt + 1'b1;
    end

    assign valid = en && (cnt >= limit);

    // R6: switching the channel off empties the counter
    p_idle_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

    // R7: the counter advances by one per cycle while it is below the limit
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        (en && cnt < limit) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
    import cmp_irq_pkg::*;
#(
    parameter int SETTLE_W = SETTLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                raw,
    input  logic                en,
    input  logic [SETTLE_W-1:0] settle,
    input  logic                clr_rise,
    input  logic                clr_fall,
    output logic                status,
    output flag_pair_t          flags
);
    logic     synced;
    logic     prev;
    logic     valid;
    edge_ev_t ev;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw),
        .q_sync  (synced)
    );

    cmp_settle #(.W(SETTLE_W)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .limit (settle),
        .valid (valid)
    );

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= synced;
    end

    assign ev = classify_edge(valid, synced, prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.rise <= next_flag(flags.rise, ev == EV_RISE, clr_rise);
            flags.fall <= next_flag(flags.fall, ev == EV_FALL, clr_fall);
        end
    end

    assign status = valid & synced;

    // R3: a set flag without a clear holds
    p_sticky_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (flags.rise && !clr_rise) |=> flags.rise);
    p_sticky_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (flags.fall && !clr_fall) |=> flags.fall);

    // R4: a clear without a competing event empties the flag
    p_clear_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_rise && ev != EV_RISE) |=> !flags.rise);

    // R5: an event beats a simultaneous clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_fall && ev == EV_FALL) |=> flags.fall);

    // R2: a falling flag only rises after a valid high-to-low step
    p_fall_src_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.fall) |-> $past(valid && prev && !synced));
endmodule

// File: rtl/cmp_edge_irq_top.sv
module cmp_edge_irq_top
    import cmp_irq_pkg::*;
#(
    parameter int NCH      = NCH_DEF,
    parameter int SETTLE_W = SETTLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0]      raw_in,
    input  logic [NCH-1:0]      ch_en,
    input  logic [NCH-1:0]      rise_ie,
    input  logic [NCH-1:0]      fall_ie,
    input  logic                glob_ie,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [NCH-1:0]      clr_rise,
    input  logic [NCH-1:0]      clr_fall,
    output logic [NCH-1:0]      status,
    output logic [NCH-1:0]      rise_flag,
    output logic [NCH-1:0]      fall_flag,
    output logic                irq
);
    flag_pair_t [NCH-1:0] ch_flags;
    logic       [NCH-1:0] ch_req;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmp_chan #(.SETTLE_W(SETTLE_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .raw      (raw_in[i]),
            .en       (ch_en[i]),
            .settle   (settle_cycles),
            .clr_rise (clr_rise[i]),
            .clr_fall (clr_fall[i]),
            .status   (status[i]),
            .flags    (ch_flags[i])
        );

        assign rise_flag[i] = ch_flags[i].rise;
        assign fall_flag[i] = ch_flags[i].fall;
        assign ch_req[i]    = (ch_flags[i].rise & rise_ie[i]) | (ch_flags[i].fall & fall_ie[i]);

        // R6: a channel that is off shows no level
        p_off_blank_r6: assert property (@(posedge clk) disable iff (rst)
            !ch_en[i] |-> !status[i]);
    end

    assign irq = glob_ie & (|ch_req);

    // R8: a request needs the global enable and at least one set flag
    p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (glob_ie && |(rise_flag | fall_flag)));

    // R10: one cycle after reset, every flag is clear
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (rise_flag == '0 && fall_flag == '0));
endmodule

// File: tb/tb_cmp_edge_irq_top.sv
module tb_cmp_edge_irq_top;
    localparam int NCH = 3;
    localparam int SW  = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] raw_in, ch_en, rise_ie, fall_ie, clr_rise, clr_fall;
    logic           glob_ie;
    logic [SW-1:0]  settle_cycles;
    logic [NCH-1:0] status, rise_flag, fall_flag;
    logic           irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmp_edge_irq_top #(.NCH(NCH), .SETTLE_W(SW)) dut (
        .clk(clk), .rst(rst), .raw_in(raw_in), .ch_en(ch_en),
        .rise_ie(rise_ie), .fall_ie(fall_ie), .glob_ie(glob_ie),
        .settle_cycles(settle_cycles), .clr_rise(clr_rise), .clr_fall(clr_fall),
        .status(status), .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_clr(input logic [NCH-1:0] r, input logic [NCH-1:0] f);
        clr_rise = r; clr_fall = f;
        tick(1);
        clr_rise = '0; clr_fall = '0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; raw_in = '0; ch_en = '0; rise_ie = '0; fall_ie = '0;
        glob_ie = 1'b0; settle_cycles = 8'd5; clr_rise = '0; clr_fall = '0;
        tick(3);
        rst = 1'b0;
        // R10 reset state
        check("R10 flags", {rise_flag, fall_flag}, '0);
        check("R10 status", status, '0);
        check("R10 irq", irq, 0);

        raw_in = 3'b111;
        tick(4);
        // R7 settle of 5 on channel 0
        ch_en[0] = 1'b1;
        tick(4);
        check("R7 blanked", status[0], 0);
        tick(1);
        check("R7 valid", status[0], 1);
        check("R7 no flag", {rise_flag[0], fall_flag[0]}, 0);

        // R7 edges inside a long window are ignored
        settle_cycles = 8'd20;
        ch_en[1] = 1'b1;
        tick(2);
        raw_in[1] = 1'b0; tick(4);
        raw_in[1] = 1'b1; tick(4);
        tick(12);
        check("R7 window ignored", {rise_flag[1], fall_flag[1]}, 0);
        check("R7 long valid", status[1], 1);

        // R1 and R2 on channel 0
        raw_in[0] = 1'b0;
        tick(1);
        check("R1 not yet", status[0], 1);
        tick(1);
        check("R1 follows", status[0], 0);
        check("R2 fall not early", fall_flag[0], 0);
        tick(1);
        check("R2 fall set", fall_flag[0], 1);
        raw_in[0] = 1'b1;
        tick(3);
        check("R2 rise set", rise_flag[0], 1);
        check("R3 fall held", fall_flag[0], 1);

        // R8 sweep of enables with both flags of channel 0 set
        for (int v = 0; v < 8; v++) begin
            rise_ie[0] = v[0]; fall_ie[0] = v[1]; glob_ie = v[2];
            #1;
            check("R8 irq sweep", irq, v[2] & (v[0] | v[1]));
        end

        // R4 clear falling flag only
        rise_ie[0] = 1'b0; fall_ie[0] = 1'b1; glob_ie = 1'b1;
        pulse_clr('0, 3'b001);
        check("R4 fall cleared", fall_flag[0], 0);
        check("R4 rise kept", rise_flag[0], 1);
        #1;
        check("R8 irq drops", irq, 0);

        // R3 further edges keep the rising flag
        raw_in[0] = 1'b0; tick(3);
        raw_in[0] = 1'b1; tick(3);
        check("R3 rise sticky", rise_flag[0], 1);

        // R5 set beats clear
        raw_in[0] = 1'b0; tick(3);
        raw_in[0] = 1'b1; tick(2);
        pulse_clr(3'b001, '0);
        check("R5 set wins", rise_flag[0], 1);
        pulse_clr(3'b001, '0);
        check("R4 rise cleared", rise_flag[0], 0);

        // R6 disable blanks, ignores edges, keeps flags
        pulse_clr(3'b001, 3'b001);
        raw_in[0] = 1'b0; tick(3);
        check("R6 pre fall", fall_flag[0], 1);
        ch_en[0] = 1'b0;
        #1;
        check("R6 status off", status[0], 0);
        tick(1);
        raw_in[0] = 1'b1; tick(3);
        raw_in[0] = 1'b0; tick(3);
        check("R6 no rise", rise_flag[0], 0);
        check("R6 fall kept", fall_flag[0], 1);

        // R7 zero settle is immediate
        settle_cycles = 8'd0;
        ch_en[2] = 1'b1;
        #1;
        check("R7 zero settle", status[2], 1);

        // R9 channel independence sweep
        ch_en = 3'b111;
        tick(1);
        raw_in = '0;
        tick(3);
        pulse_clr(3'b111, 3'b111);
        for (int p = 1; p < 8; p++) begin
            pulse_clr(3'b111, 3'b111);
            raw_in = p[2:0]; tick(3);
            check("R9 rise map", rise_flag, p[2:0]);
            check("R9 fall clean", fall_flag, 0);
            raw_in = '0; tick(3);
            check("R9 fall map", fall_flag, p[2:0]);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule